// File: doc/BRIEF.md
# Systolic Adder-Chain FIR Filter

This block is a fully parallel finite impulse response filter. Every coefficient has its own multiplier. The taps are laid out as a systolic chain. Each tap adds its registered product to a partial sum that arrives registered from the tap before it. The running sum therefore ripples along the chain one tap per clock, and no adder tree is needed at the end. So that every product meets the partial sum it belongs to, the input sample walks along the taps through two registers per tap. The last tap's sum register drives the filter output.

Coefficients are fixed at elaboration through a packed parameter vector. The block accepts one sample on every clock and returns one full-precision result on every clock after a fixed latency. A cycle without a valid input pushes a zero sample into the delay line, and the pipeline keeps moving. The output valid flag is the input valid flag delayed by the same latency.

Top module: `chain_fir`

## Requirements
- R1: The active-low asynchronous reset `rst_ni` immediately forces `out_valid_o` to 0 and `y_o` to 0, and it clears every tap's sample and sum registers. The first results after reset, including after a reset in the middle of a stream, treat all earlier samples as zero.
- R2: The result for the sample x(n) is y(n) = sum over k = 0..NUM_TAPS-1 of c_k * x(n-k). Here c_k is the signed value in COEF_VEC[k*COEF_W +: COEF_W], and k = 0 weights the newest sample. Samples are signed two's complement.
- R3: A sample taken at one clock edge reaches `y_o` after LATENCY edges, counting that edge, where LATENCY = NUM_TAPS + MUL_PIPE + 2. `out_valid_o` equals `in_valid_i` delayed by the same LATENCY edges.
- R4: A new sample is accepted on every clock. An unbroken run of valid inputs yields an unbroken run of valid outputs of the same length.
- R5: On a cycle with `in_valid_i` = 0, a zero enters the delay line in place of `in_data_i`, and the matching output slot has `out_valid_o` = 0.
- R6: `y_o` is the exact ACC_W-bit two's complement sum with no truncation or wrap. This includes runs of the most negative sample against the most negative and most positive coefficient.
- R7: A single sample of value 1, surrounded by zeros, produces c_0, c_1, ... c_(NUM_TAPS-1) on consecutive clocks.
- R8: Once NUM_TAPS + LATENCY consecutive inputs have been zero or invalid, `y_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample qualifier |
| in_data_i | input | DATA_W | Signed input sample |
| out_valid_o | output | 1 | Result qualifier, in_valid_i delayed by LATENCY |
| y_o | output | ACC_W | Signed full-precision filter result |

## Verification
The convolution is tested with several kinds of input:
- A mixed table of signed values with gaps in it. This separates correct zero insertion and correct valid alignment from a pipeline that stalls or fails to shift.
- A unit impulse. This shows whether the coefficients come out in the right order and whether the two-register data path lines up with the sum chain. A one-register skew shows up as a smeared response.
- Runs of extreme samples. These expose any truncation in the product or the sum.
- A long full-rate pseudo-random stream. This checks back-to-back throughput.
- A reset in the middle of a stream. This shows that no old history leaks into new results.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int DATA_W   = 16;
  localparam int COEF_W   = 18;
  localparam int ACC_W    = 48;
  localparam int DEF_TAPS = 23;

  // Symmetric triangular default response
  function automatic logic [DEF_TAPS*COEF_W-1:0] default_coefs();
    logic [DEF_TAPS*COEF_W-1:0] v;
    int mid;
    int c;
    v   = '0;
    mid = DEF_TAPS / 2;
    for (int k = 0; k < DEF_TAPS; k++) begin
      c = 1000 * (mid + 1 - ((k > mid) ? (k - mid) : (mid - k))) - 3000;
      v[k*COEF_W +: COEF_W] = COEF_W'(c);
    end
    return v;
  endfunction
endpackage

// File: rtl/fir_mul_pipe.sv
module fir_mul_pipe #(
  parameter int A_W   = 16,
  parameter int B_W   = 18,
  parameter int DEPTH = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [A_W-1:0]      a_i,
  input  logic signed [B_W-1:0]      b_i,
  output logic signed [A_W+B_W-1:0]  p_o
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] a_ext, b_ext;
  logic signed [P_W-1:0] st_q [DEPTH];

  assign a_ext = {{B_W{a_i[A_W-1]}}, a_i};
  assign b_ext = {{A_W{b_i[B_W-1]}}, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= a_ext * b_ext;
      for (int i = 1; i < DEPTH; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign p_o = st_q[DEPTH-1];
endmodule

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 18,
  parameter int ACC_W    = 48,
  parameter int MUL_PIPE = 1,
  parameter logic signed [COEF_W-1:0] COEF = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] x_o,
  input  logic signed [ACC_W-1:0]  sum_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] x_a_q, x_b_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum_q;

  // Two sample registers per tap match the one-register step of the sum chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_a_q <= '0;
      x_b_q <= '0;
    end else begin
      x_a_q <= x_i;
      x_b_q <= x_a_q;
    end
  end

  fir_mul_pipe #(
    .A_W   (DATA_W),
    .B_W   (COEF_W),
    .DEPTH (MUL_PIPE)
  ) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (x_b_q),
    .b_i    (COEF),
    .p_o    (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_i + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  assign x_o   = x_b_q;
  assign sum_o = sum_q;
endmodule

// File: rtl/fir_valid_pipe.sv
module fir_valid_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= valid_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DEPTH-2:0], valid_i};
      end
    end
  endgenerate

  assign valid_o = sr_q[DEPTH-1];
endmodule

// File: rtl/chain_fir.sv
module chain_fir #(
  parameter int NUM_TAPS = fir_pkg::DEF_TAPS,
  parameter int DATA_W   = fir_pkg::DATA_W,
  parameter int COEF_W   = fir_pkg::COEF_W,
  parameter int ACC_W    = fir_pkg::ACC_W,
  parameter int MUL_PIPE = 1,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = fir_pkg::default_coefs()
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic signed [ACC_W-1:0]  y_o
);
  localparam int LATENCY = NUM_TAPS + MUL_PIPE + 2;

  logic signed [DATA_W-1:0] x_w   [NUM_TAPS+1];
  logic signed [ACC_W-1:0]  sum_w [NUM_TAPS+1];

  // Empty slots feed zeros so the stream stays time-aligned
  assign x_w[0]   = in_valid_i ? in_data_i : '0;
  assign sum_w[0] = '0;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    fir_tap #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .ACC_W    (ACC_W),
      .MUL_PIPE (MUL_PIPE),
      .COEF     (COEF_VEC[g*COEF_W +: COEF_W])
    ) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .x_i    (x_w[g]),
      .x_o    (x_w[g+1]),
      .sum_i  (sum_w[g]),
      .sum_o  (sum_w[g+1])
    );
  end

  fir_valid_pipe #(
    .DEPTH (LATENCY)
  ) u_vld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .valid_o (out_valid_o)
  );

  assign y_o = sum_w[NUM_TAPS];
endmodule

// File: rtl/chain_fir_chk.sv
module chain_fir_chk #(
  parameter int NUM_TAPS = 23,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 48,
  parameter int LATENCY  = 26
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic signed [DATA_W-1:0] in_data_i,
  input logic                     out_valid_o,
  input logic signed [ACC_W-1:0]  y_o
);
  localparam int RUN_LIM = NUM_TAPS + LATENCY;

  logic [31:0] age_q, in_cnt_q, out_cnt_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q     <= '0;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      run_q     <= '0;
    end else begin
      if (age_q < 32'(LATENCY)) age_q <= age_q + 32'd1;
      if (in_valid_i)  in_cnt_q  <= in_cnt_q + 32'd1;
      if (out_valid_o) out_cnt_q <= out_cnt_q + 32'd1;
      if (in_valid_i && in_data_i != '0) run_q <= '0;
      else if (run_q < 32'(RUN_LIM))     run_q <= run_q + 32'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && y_o == '0)); // R1

  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q < 32'(LATENCY)) |-> !out_valid_o); // R3

  AST_VALID_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt_q <= in_cnt_q) && ((in_cnt_q - out_cnt_q) <= 32'(LATENCY))); // R3

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= 32'(RUN_LIM)) |-> (y_o == '0)); // R8
endmodule

bind chain_fir chain_fir_chk #(
  .NUM_TAPS (NUM_TAPS),
  .DATA_W   (DATA_W),
  .ACC_W    (ACC_W),
  .LATENCY  (LATENCY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .y_o         (y_o)
);

// File: tb/chain_fir_tb.sv
`timescale 1ns/1ps
module chain_fir_tb;
  localparam int N     = 23;
  localparam int DW    = 16;
  localparam int CW    = 18;
  localparam int AW    = 48;
  localparam int MP    = 1;
  localparam int LAT   = N + MP + 2;
  localparam int HSIZE = 1024;

  function automatic longint tb_coef(int k);
    if (k == 0)     return -131072;
    if (k == N - 1) return 131071;
    return longint'(((k * 2917 + 501) % 4001) - 2000);
  endfunction

  function automatic logic [N*CW-1:0] tb_coef_vec();
    logic [N*CW-1:0] v;
    for (int k = 0; k < N; k++) v[k*CW +: CW] = CW'(tb_coef(k));
    return v;
  endfunction

  // {valid, data}
  localparam logic [16:0] STIM [32] = '{
    {1'b1, 16'h04B0}, {1'b1, 16'hFC18}, {1'b1, 16'h7FFF}, {1'b1, 16'h8000},
    {1'b0, 16'h1234}, {1'b1, 16'h0001}, {1'b1, 16'hFFFF}, {1'b0, 16'h5555},
    {1'b0, 16'hAAAA}, {1'b1, 16'h3A98}, {1'b1, 16'hC568}, {1'b1, 16'h0000},
    {1'b1, 16'h0100}, {1'b1, 16'hF000}, {1'b1, 16'h2710}, {1'b0, 16'h7FFF},
    {1'b1, 16'h0ABC}, {1'b1, 16'hE000}, {1'b1, 16'h1F40}, {1'b1, 16'h8001},
    {1'b1, 16'h6000}, {1'b0, 16'h0001}, {1'b1, 16'h00FF}, {1'b1, 16'hFF00},
    {1'b1, 16'h0F0F}, {1'b1, 16'hF0F0}, {1'b1, 16'h4000}, {1'b1, 16'hBFFF},
    {1'b0, 16'h0000}, {1'b1, 16'h0007}, {1'b1, 16'hFFF9}, {1'b1, 16'h2222}
  };

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic                 in_valid_i;
  logic signed [DW-1:0] in_data_i;
  logic                 out_valid_o;
  logic signed [AW-1:0] y_o;

  int     n_chk = 0;
  int     n_bad = 0;
  int     cyc   = 0;
  bit     done  = 1'b0;
  longint hist [HSIZE];
  bit     vh   [HSIZE];

  always #4 clk_i = ~clk_i;

  chain_fir #(
    .NUM_TAPS (N),
    .DATA_W   (DW),
    .COEF_W   (CW),
    .ACC_W    (AW),
    .MUL_PIPE (MP),
    .COEF_VEC (tb_coef_vec())
  ) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .y_o         (y_o)
  );

  function automatic longint ref_y(int m);
    longint s = 0;
    for (int k = 0; k < N; k++)
      if (m - k >= 0) s += tb_coef(k) * hist[m-k];
    return s;
  endfunction

  task automatic chk_y(string tag, longint exp_y);
    longint got;
    got = longint'(y_o);
    n_chk++;
    if (got != exp_y) begin
      n_bad++;
      $display("FAIL %s y_o cyc=%0d got=%0d exp=%0d", tag, cyc, got, exp_y);
    end
  endtask

  task automatic chk_v(string tag, bit exp_v);
    n_chk++;
    if (out_valid_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s out_valid_o cyc=%0d got=%0b exp=%0b", tag, cyc, out_valid_o, exp_v);
    end
  endtask

  // Result for the sample of edge m is visible after edge m+LAT-1
  task automatic step(bit v, logic [DW-1:0] d, string tag);
    int m;
    @(negedge clk_i);
    in_valid_i = v;
    in_data_i  = d;
    @(posedge clk_i);
    if (cyc < HSIZE) begin
      hist[cyc] = v ? longint'($signed(d)) : 0;
      vh[cyc]   = v;
    end
    cyc++;
    #2;
    m = cyc - LAT;
    chk_v(tag, (m >= 0) ? vh[m] : 1'b0);
    chk_y(tag, (m >= 0) ? ref_y(m) : 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni     = 1'b0;
    in_valid_i = 1'b0;
    in_data_i  = '0;
    #1;
    chk_v("R1 reset", 1'b0);
    chk_y("R1 reset", 0);
    for (int i = 0; i < HSIZE; i++) begin
      hist[i] = 0;
      vh[i]   = 1'b0;
    end
    cyc = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni     = 1'b1;
    in_valid_i = 1'b0;
    in_data_i  = '0;
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    do_reset();

    // R2 R3 R5: table walk, then drain
    for (int i = 0; i < 32; i++) step(STIM[i][16], STIM[i][15:0], "R2/R3/R5 table");
    for (int i = 0; i < LAT + N; i++) step(1'b0, 16'h0000, "R3/R5 drain");

    // R1: reset mid-stream must drop history
    for (int i = 0; i < 10; i++) step(1'b1, 16'h7FFF, "R1 prefill");
    do_reset();
    for (int i = 0; i < LAT + 4; i++) step(1'b1, 16'h0003, "R1 after reset");

    // R7: impulse gives coefficients in order
    do_reset();
    step(1'b1, 16'h0001, "R7 impulse");
    for (int i = 0; i < LAT + N; i++) step(1'b0, 16'h0000, "R7 impulse");

    // R6: extremes, no wrap
    do_reset();
    for (int i = 0; i < LAT + N; i++) step(1'b1, 16'h8000, "R6 min run");
    for (int i = 0; i < LAT + N; i++) step(1'b1, (i % 2 == 0) ? 16'h7FFF : 16'h8000, "R6 alternate");

    // R8: flush to zero
    for (int i = 0; i < LAT + N; i++) step(1'b0, 16'h8000, "R8 flush");
    chk_y("R8 flushed", 0);

    // R4: full-rate stream
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 180; i++) begin
      step(1'b1, lfsr, "R4 full rate");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    for (int i = 0; i < LAT - 1; i++) step(1'b0, 16'h0000, "R4 tail");
    chk_v("R4 last valid", 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule